// File: doc/BRIEF.md
# Selectable Bit-Error-Rate Test Pattern Source

This block is the transmit half of a bit-error-rate tester. On every cycle where the clock enable `bit_en` is high, it emits one serial test bit. It also flags that bit with `tx_valid` one cycle later. A 3-bit select field in a host control byte picks the sequence. The choices are four maximal-length pseudorandom sequences, a zero-run-limited pseudorandom sequence, a user word of programmable length, an alternating pair of user words, and a reserved code that sends steady ones.

The host writes the control byte at any time, but a new pattern is adopted only on a 0-to-1 transition of the byte's load bit. On that cycle the select code, the user words, the word length and the repeat count are captured. Every generator is reseeded at the same moment. The transmit-invert bit is not captured: it acts on each bit as that bit is produced. A line interface or a time-slot mapper downstream consumes `tx_bit` whenever `tx_valid` is high.

Top module: `bert_pattern_gen`

## Requirements
- R1: After reset, `tx_valid` and `tx_bit` are 0, the selected pattern is code 000 with all generators seeded to all-ones, the captured user words, length and count are 0, and no inversion is applied.
- R2: Codes 000, 111, 001 and 010 select shift-register sequences of length 7 (feedback taps 7,6), 9 (taps 9,5), 11 (taps 11,9) and 15 (taps 15,14). For a register s of length N with second tap T, each produced bit is s[N-1] xor s[T-1], and that bit is then shifted into s[0]. Each register is seeded to all-ones by reset and by every load.
- R3: Code 011 selects a 20-bit register with taps 20,17, stepped as in R2. When the previous 14 produced bits of this pattern (before inversion) were all 0, the next output is forced to 1. The forcing does not alter the register.
- R4: Code 100 sends the captured 32-bit user word, using the low L = user_len+1 bits, from bit L-1 down to bit 0, and then repeats.
- R5: Code 101 sends captured word A from bit 15 to bit 0, `alt_count`+1 times. It then sends captured word B the same number of times, and the cycle repeats, starting with A after each load.
- R6: Code 110 produces a constant 1 before inversion.
- R7: Bit 4 of `ctrl_byte` inverts the bit produced in the same cycle. It takes effect without a load.
- R8: Bit 0 of `ctrl_byte` is the load bit and bits 3:1 are the select field. A load happens only when bit 0 is 1 in a cycle after a cycle in which it was 0. A load cycle produces no bit. Holding bit 0 high, or changing the select field while it stays high, causes no further load.
- R9: `tx_valid` is 1 exactly one cycle after a cycle with `bit_en` high that was not a load cycle. When no bit is produced, `tx_bit` holds its value and the pattern state does not advance.
- R10: Changes to `user_word`, `user_len`, `alt_word_a`, `alt_word_b`, `alt_count`, or bits 7:5 of `ctrl_byte`, have no effect on the output until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Produce one bit this cycle |
| ctrl_byte | input | 8 | Host control: bit 0 load, bits 3:1 select, bit 4 invert |
| user_word | input | 32 | Word for the repeating user pattern |
| user_len | input | 5 | Repeating pattern length minus one |
| alt_word_a | input | 16 | First word of the alternating pattern |
| alt_word_b | input | 16 | Second word of the alternating pattern |
| alt_count | input | 8 | Repeats per word minus one |
| tx_bit | output | 1 | Serial test bit |
| tx_valid | output | 1 | tx_bit was produced in the previous cycle |

## Verification
Each pseudorandom code is run under gapped random enables with random inversion. These runs separate the tap positions, the seed value and the rule that the state advances only when a bit is produced. A long run of the zero-limited code shows whether zero runs are capped without the capping disturbing the register. User-word runs use lengths 1, 32 and a random value, and alternating-word runs use repeat counts 1, 3 and 256. These cases separate the wrap points of the two bit indices and of the repeat counter. Directed load sequences cover the following: a load held high while the select field changes, a load coinciding with an enable, and user inputs changed with no load. These show that only a rising load bit changes the pattern.

// File: rtl/bert_pkg.sv
`timescale 1ns/1ps
package bert_pkg;

   typedef enum logic [2:0] {
      PAT_PRBS7   = 3'd0,
      PAT_PRBS11  = 3'd1,
      PAT_PRBS15  = 3'd2,
      PAT_QRSS    = 3'd3,
      PAT_REPEAT  = 3'd4,
      PAT_ALTWORD = 3'd5,
      PAT_OCTET55 = 3'd6,
      PAT_PRBS9   = 3'd7
   } pat_sel_e;

   localparam int NUM_LFSR     = 5;
   localparam int QRSS_SLOT    = 4;
   localparam int CTL_LOAD_BIT = 0;
   localparam int CTL_SEL_LSB  = 1;
   localparam int CTL_INV_BIT  = 4;

   function automatic int lfsr_len(input int slot);
      case (slot)
         0:       return 7;
         1:       return 9;
         2:       return 11;
         3:       return 15;
         default: return 20;
      endcase
   endfunction

   function automatic int lfsr_tap(input int slot);
      case (slot)
         0:       return 6;
         1:       return 5;
         2:       return 9;
         3:       return 14;
         default: return 17;
      endcase
   endfunction

   function automatic logic uses_lfsr(input logic [2:0] sel);
      return (sel != PAT_REPEAT) && (sel != PAT_ALTWORD) && (sel != PAT_OCTET55);
   endfunction

   function automatic int lfsr_slot(input logic [2:0] sel);
      case (sel)
         PAT_PRBS7:  return 0;
         PAT_PRBS9:  return 1;
         PAT_PRBS11: return 2;
         PAT_PRBS15: return 3;
         PAT_QRSS:   return 4;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/bert_lfsr.sv
`timescale 1ns/1ps
module bert_lfsr #(
   parameter int LEN = 7,
   parameter int TAP = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_i,
   input  logic step_i,
   output logic bit_o
);
   if (LEN < 3) begin : g_bad_len
      $error("bert_lfsr: LEN must be at least 3");
   end
   if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
      $error("bert_lfsr: TAP must lie in 1..LEN-1");
   end

   logic [LEN-1:0] state;

   assign bit_o = state[LEN-1] ^ state[TAP-1];

   always_ff @(posedge clk) begin
      if (!rst_n || seed_i) begin
         state <= '1;
      end else if (step_i) begin
         state <= {state[LEN-2:0], bit_o};
      end
   end
endmodule

// File: rtl/bert_zero_cap.sv
`timescale 1ns/1ps
module bert_zero_cap #(
   parameter int ZRUN_MAX = 14,
   localparam int RUN_W = $clog2(ZRUN_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   input  logic raw_i,
   output logic bit_o
);
   if (ZRUN_MAX < 1) begin : g_bad_max
      $error("bert_zero_cap: ZRUN_MAX must be at least 1");
   end

   logic [RUN_W-1:0] run_q;
   logic             at_cap;

   assign at_cap = (run_q == RUN_W'(ZRUN_MAX));
   assign bit_o  = at_cap | raw_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         run_q <= '0;
      end else if (step_i) begin
         run_q <= bit_o ? '0 : run_q + 1'b1;
      end
   end
endmodule

// File: rtl/bert_user_pat.sv
`timescale 1ns/1ps
module bert_user_pat #(
   parameter int USER_W    = 32,
   parameter int ALT_W     = 16,
   parameter int ALT_CNT_W = 8,
   localparam int IDX_W    = $clog2(USER_W),
   localparam int AIDX_W   = $clog2(ALT_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 seed_i,
   input  logic                 step_rep_i,
   input  logic                 step_alt_i,
   input  logic [USER_W-1:0]    word_i,
   input  logic [IDX_W-1:0]     len_i,
   input  logic [ALT_W-1:0]     alt_a_i,
   input  logic [ALT_W-1:0]     alt_b_i,
   input  logic [ALT_CNT_W-1:0] alt_cnt_i,
   output logic                 rep_bit_o,
   output logic                 alt_bit_o
);
   if (USER_W < 2) begin : g_bad_user
      $error("bert_user_pat: USER_W must be at least 2");
   end
   if (ALT_W < 2) begin : g_bad_alt
      $error("bert_user_pat: ALT_W must be at least 2");
   end

   localparam logic [IDX_W-1:0]  LEN_TOP = IDX_W'(USER_W - 1);
   localparam logic [AIDX_W-1:0] ALT_TOP = AIDX_W'(ALT_W - 1);

   logic [IDX_W-1:0] len_eff;

   if ((1 << IDX_W) == USER_W) begin : g_len_pow2
      assign len_eff = len_i;
   end else begin : g_len_clamp
      assign len_eff = (len_i > LEN_TOP) ? LEN_TOP : len_i;
   end

   // repeating user word
   logic [USER_W-1:0] word_q;
   logic [IDX_W-1:0]  len_q;
   logic [IDX_W-1:0]  ridx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         len_q  <= '0;
         ridx_q <= '0;
      end else if (seed_i) begin
         word_q <= word_i;
         len_q  <= len_eff;
         ridx_q <= len_eff;
      end else if (step_rep_i) begin
         ridx_q <= (ridx_q == '0) ? len_q : ridx_q - 1'b1;
      end
   end

   assign rep_bit_o = word_q[ridx_q];

   // alternating word pair
   logic [ALT_W-1:0]     a_q;
   logic [ALT_W-1:0]     b_q;
   logic [ALT_CNT_W-1:0] cnt_q;
   logic [ALT_CNT_W-1:0] rep_q;
   logic [AIDX_W-1:0]    aidx_q;
   logic                 use_b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         cnt_q   <= '0;
         rep_q   <= '0;
         aidx_q  <= ALT_TOP;
         use_b_q <= 1'b0;
      end else if (seed_i) begin
         a_q     <= alt_a_i;
         b_q     <= alt_b_i;
         cnt_q   <= alt_cnt_i;
         rep_q   <= '0;
         aidx_q  <= ALT_TOP;
         use_b_q <= 1'b0;
      end else if (step_alt_i) begin
         if (aidx_q == '0) begin
            aidx_q <= ALT_TOP;
            if (rep_q == cnt_q) begin
               rep_q   <= '0;
               use_b_q <= ~use_b_q;
            end else begin
               rep_q <= rep_q + 1'b1;
            end
         end else begin
            aidx_q <= aidx_q - 1'b1;
         end
      end
   end

   assign alt_bit_o = use_b_q ? b_q[aidx_q] : a_q[aidx_q];
endmodule

// File: rtl/bert_pattern_gen.sv
`timescale 1ns/1ps
module bert_pattern_gen
   import bert_pkg::*;
#(
   parameter int USER_W     = 32,
   parameter int ALT_W      = 16,
   parameter int ALT_CNT_W  = 8,
   parameter int ZRUN_MAX   = 14,
   localparam int USER_IDX_W = $clog2(USER_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_en,
   input  logic [7:0]            ctrl_byte,
   input  logic [USER_W-1:0]     user_word,
   input  logic [USER_IDX_W-1:0] user_len,
   input  logic [ALT_W-1:0]      alt_word_a,
   input  logic [ALT_W-1:0]      alt_word_b,
   input  logic [ALT_CNT_W-1:0]  alt_count,
   output logic                  tx_bit,
   output logic                  tx_valid
);
   if (ALT_CNT_W < 1) begin : g_bad_cnt
      $error("bert_pattern_gen: ALT_CNT_W must be at least 1");
   end

   logic       unused_ctrl;
   assign unused_ctrl = ^ctrl_byte[7:5];

   logic       load_q;
   logic       load_pulse;
   logic [2:0] sel_q;
   logic       produce;
   logic       invert;

   assign load_pulse = ctrl_byte[CTL_LOAD_BIT] & ~load_q;
   assign produce    = bit_en & ~load_pulse;
   assign invert     = ctrl_byte[CTL_INV_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q <= 1'b0;
         sel_q  <= PAT_PRBS7;
      end else begin
         load_q <= ctrl_byte[CTL_LOAD_BIT];
         if (load_pulse) begin
            sel_q <= ctrl_byte[CTL_SEL_LSB +: 3];
         end
      end
   end

   // shift-register bank, one per sequence length
   logic [NUM_LFSR-1:0] lfsr_bit;
   logic                lfsr_mode;
   int                  active_slot;

   assign lfsr_mode   = uses_lfsr(sel_q);
   assign active_slot = lfsr_slot(sel_q);

   for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lfsr
      localparam int LEN = lfsr_len(g);
      localparam int TAP = lfsr_tap(g);
      logic step_g;
      assign step_g = produce & lfsr_mode & (active_slot == g);
      bert_lfsr #(.LEN(LEN), .TAP(TAP)) u_lfsr (
         .clk    (clk),
         .rst_n  (rst_n),
         .seed_i (load_pulse),
         .step_i (step_g),
         .bit_o  (lfsr_bit[g])
      );
   end

   // zero-run limiter on the long sequence
   logic qrss_bit;
   bert_zero_cap #(.ZRUN_MAX(ZRUN_MAX)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load_pulse),
      .step_i  (produce && (sel_q == PAT_QRSS)),
      .raw_i   (lfsr_bit[QRSS_SLOT]),
      .bit_o   (qrss_bit)
   );

   // user patterns
   logic rep_bit;
   logic alt_bit;
   bert_user_pat #(.USER_W(USER_W), .ALT_W(ALT_W), .ALT_CNT_W(ALT_CNT_W)) u_user (
      .clk        (clk),
      .rst_n      (rst_n),
      .seed_i     (load_pulse),
      .step_rep_i (produce && (sel_q == PAT_REPEAT)),
      .step_alt_i (produce && (sel_q == PAT_ALTWORD)),
      .word_i     (user_word),
      .len_i      (user_len),
      .alt_a_i    (alt_word_a),
      .alt_b_i    (alt_word_b),
      .alt_cnt_i  (alt_count),
      .rep_bit_o  (rep_bit),
      .alt_bit_o  (alt_bit)
   );

   logic raw_bit;
   always_comb begin
      case (sel_q)
         PAT_QRSS:    raw_bit = qrss_bit;
         PAT_REPEAT:  raw_bit = rep_bit;
         PAT_ALTWORD: raw_bit = alt_bit;
         PAT_OCTET55: raw_bit = 1'b1;
         default:     raw_bit = lfsr_bit[active_slot];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_bit   <= 1'b0;
         tx_valid <= 1'b0;
      end else begin
         tx_valid <= produce;
         if (produce) begin
            tx_bit <= raw_bit ^ invert;
         end
      end
   end
endmodule

// File: rtl/bert_pattern_gen_chk.sv
`timescale 1ns/1ps
module bert_pattern_gen_chk #(
   parameter int ZRUN_MAX = 14
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_en,
   input logic [7:0] ctrl_byte,
   input logic       tx_bit,
   input logic       tx_valid,
   input logic [2:0] sel_q
);
   logic       load_prev;
   logic       inv_d;
   logic [7:0] zcnt;
   logic       rising;
   logic       raw_out;

   assign rising  = ctrl_byte[0] & ~load_prev;
   assign raw_out = tx_bit ^ inv_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_prev <= 1'b0;
         inv_d     <= 1'b0;
         zcnt      <= '0;
      end else begin
         load_prev <= ctrl_byte[0];
         if (bit_en) inv_d <= ctrl_byte[4];
         if (rising) begin
            zcnt <= '0;
         end else if (tx_valid && sel_q == 3'd3) begin
            if (raw_out) zcnt <= '0;
            else if (zcnt != 8'hff) zcnt <= zcnt + 1'b1;
         end
      end
   end

   // R9: valid one cycle after an enabled, non-load cycle
   a_r9_valid_tracks_en: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !rising) |=> tx_valid);
   a_r9_no_valid_without_en: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> !tx_valid);
   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));
   // R8: load cycle produces no bit; held load does not reload
   a_r8_load_blocks_bit: assert property (@(posedge clk) disable iff (!rst_n)
      rising |=> !tx_valid);
   a_r8_held_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_byte[0] && load_prev) |=> $stable(sel_q));
   // R6: reserved code sends ones before inversion
   a_r6_octet_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && sel_q == 3'd6) |-> raw_out);
   // R3: zero runs of the limited sequence never exceed the cap
   a_r3_zero_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
      zcnt <= 8'(ZRUN_MAX));
endmodule

bind bert_pattern_gen bert_pattern_gen_chk #(.ZRUN_MAX(ZRUN_MAX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .ctrl_byte (ctrl_byte),
   .tx_bit    (tx_bit),
   .tx_valid  (tx_valid),
   .sel_q     (sel_q)
);

// File: tb/bert_pattern_gen_tb.sv
`timescale 1ns/1ps
module bert_pattern_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic [7:0]  ctrl_byte = 8'h00;
   logic [31:0] user_word = '0;
   logic [4:0]  user_len = '0;
   logic [15:0] alt_word_a = '0;
   logic [15:0] alt_word_b = '0;
   logic [7:0]  alt_count = '0;
   logic        tx_bit;
   logic        tx_valid;

   always #2 clk = ~clk;

   bert_pattern_gen u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ctrl_byte(ctrl_byte),
      .user_word(user_word), .user_len(user_len), .alt_word_a(alt_word_a),
      .alt_word_b(alt_word_b), .alt_count(alt_count),
      .tx_bit(tx_bit), .tx_valid(tx_valid)
   );

   int    total = 0;
   int    bad = 0;
   int    forced = 0;
   string tag = "R1";

   // reference model state
   logic [31:0] m_l [5];
   logic [2:0]  m_sel;
   logic        m_prev_ld;
   logic [31:0] m_word;
   logic [4:0]  m_len, m_ridx;
   logic [15:0] m_a, m_b;
   logic [7:0]  m_cnt, m_arep;
   logic [3:0]  m_aidx;
   logic        m_asel;
   int          m_zrun;
   logic        e_bit, e_valid;

   function automatic int ln(input int i);
      case (i) 0: return 7; 1: return 9; 2: return 11; 3: return 15; default: return 20; endcase
   endfunction
   function automatic int tp(input int i);
      case (i) 0: return 6; 1: return 5; 2: return 9; 3: return 14; default: return 17; endcase
   endfunction
   function automatic int slot(input logic [2:0] s);
      case (s) 3'd0: return 0; 3'd7: return 1; 3'd1: return 2; 3'd2: return 3; default: return 4; endcase
   endfunction

   task automatic seed_all();
      for (int i = 0; i < 5; i++) m_l[i] = (32'h1 << ln(i)) - 1;
      m_zrun = 0;
   endtask

   task automatic model_load(input logic [2:0] s);
      m_sel = s;
      seed_all();
      m_word = user_word; m_len = user_len; m_ridx = user_len;
      m_a = alt_word_a; m_b = alt_word_b; m_cnt = alt_count;
      m_aidx = 4'd15; m_arep = 0; m_asel = 0;
   endtask

   task automatic lfsr_step(input int i, output logic fb);
      fb = m_l[i][ln(i)-1] ^ m_l[i][tp(i)-1];
      m_l[i] = ((m_l[i] << 1) | 32'(fb)) & ((32'h1 << ln(i)) - 1);
   endtask

   task automatic model_next(output logic raw);
      logic fb;
      case (m_sel)
         3'd3: begin
            lfsr_step(4, fb);
            if (m_zrun == 14) begin raw = 1'b1; forced++; end
            else raw = fb;
            m_zrun = raw ? 0 : m_zrun + 1;
         end
         3'd4: begin
            raw = m_word[m_ridx];
            m_ridx = (m_ridx == 0) ? m_len : m_ridx - 1;
         end
         3'd5: begin
            raw = m_asel ? m_b[m_aidx] : m_a[m_aidx];
            if (m_aidx == 0) begin
               m_aidx = 4'd15;
               if (m_arep == m_cnt) begin m_arep = 0; m_asel = ~m_asel; end
               else m_arep = m_arep + 1;
            end else m_aidx = m_aidx - 1;
         end
         3'd6: raw = 1'b1;
         default: lfsr_step(slot(m_sel), raw);
      endcase
   endtask

   task automatic check_out();
      total++;
      if (tx_valid !== e_valid) begin
         bad++;
         $display("FAIL %s tx_valid actual=%b expected=%b t=%0t", tag, tx_valid, e_valid, $time);
      end else if (tx_bit !== e_bit) begin
         bad++;
         $display("FAIL %s tx_bit actual=%b expected=%b t=%0t", tag, tx_bit, e_bit, $time);
      end
   endtask

   task automatic tick(input logic en, input logic [7:0] c);
      logic ld, raw;
      bit_en = en; ctrl_byte = c;
      ld = c[0] & ~m_prev_ld;
      m_prev_ld = c[0];
      if (ld) begin model_load(c[3:1]); e_valid = 0; end
      else if (en) begin model_next(raw); e_bit = raw ^ c[4]; e_valid = 1; end
      else e_valid = 0;
      @(posedge clk);
      @(negedge clk);
      check_out();
   endtask

   function automatic logic [7:0] cb(input logic inv, input logic [2:0] s, input logic ld);
      return {3'($urandom_range(7)), inv, s, ld};
   endfunction

   task automatic load(input logic [2:0] s);
      tick(1'b0, cb(1'b0, s, 1'b0));
      tick(1'b1, cb(1'b0, s, 1'b1));
   endtask

   task automatic run(input int n, input logic [2:0] s, input int en_pct, input logic rand_inv);
      for (int k = 0; k < n; k++)
         tick(($urandom_range(99) < en_pct), cb(rand_inv ? 1'($urandom_range(1)) : 1'b0, s, 1'b0));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h2b5e_11d7));
      m_sel = 0; m_prev_ld = 0; m_word = 0; m_len = 0; m_ridx = 0;
      m_a = 0; m_b = 0; m_cnt = 0; m_aidx = 4'd15; m_arep = 0; m_asel = 0;
      seed_all();
      e_bit = 0; e_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, then default sequence without any load
      tag = "R1"; check_out();
      tick(1'b0, 8'h00);
      run(60, 3'd0, 100, 1'b0);

      // R2: the four plain sequences, gapped enables, random invert
      tag = "R2";
      foreach (m_l[i]) begin end
      load(3'd0); run(300, 3'd0, 70, 1'b1);
      load(3'd7); run(600, 3'd7, 70, 1'b1);
      load(3'd1); run(2500, 3'd1, 80, 1'b1);
      load(3'd2); run(1500, 3'd2, 80, 1'b1);

      // R7: invert toggled every cycle without reload
      tag = "R7";
      load(3'd1); run(400, 3'd1, 100, 1'b1);

      // R4: repeating user word at lengths 1, 32 and random
      tag = "R4";
      user_word = $urandom(); user_len = 5'd0;  load(3'd4); run(40, 3'd4, 75, 1'b0);
      user_word = $urandom(); user_len = 5'd31; load(3'd4); run(200, 3'd4, 75, 1'b1);
      user_word = $urandom(); user_len = 5'($urandom_range(30)); load(3'd4); run(150, 3'd4, 75, 1'b0);

      // R10: inputs change with no load, pattern must stay
      tag = "R10";
      for (int k = 0; k < 120; k++) begin
         user_word = $urandom(); user_len = 5'($urandom_range(31));
         alt_word_a = 16'($urandom()); alt_count = 8'($urandom());
         tick(1'b1, cb(1'b0, 3'd4, 1'b0));
      end

      // R5: alternating words with repeat counts 1, 3, 256
      tag = "R5";
      alt_word_a = 16'($urandom()); alt_word_b = 16'($urandom());
      alt_count = 8'd0;   load(3'd5); run(200, 3'd5, 80, 1'b0);
      alt_count = 8'd2;   load(3'd5); run(300, 3'd5, 80, 1'b1);
      alt_count = 8'd255; load(3'd5); run(8400, 3'd5, 100, 1'b0);

      // R6: reserved code, with and without invert
      tag = "R6";
      load(3'd6); run(80, 3'd6, 70, 1'b1);

      // R8: held load with a changing select; load coinciding with enable
      tag = "R8";
      load(3'd0);
      for (int k = 0; k < 60; k++) tick(1'b1, cb(1'b0, 3'($urandom_range(7)), 1'b1));
      tick(1'b1, cb(1'b0, 3'd2, 1'b0));
      tick(1'b1, cb(1'b0, 3'd2, 1'b1));
      run(200, 3'd2, 100, 1'b0);
      tick(1'b1, cb(1'b0, 3'd7, 1'b1));
      run(40, 3'd7, 100, 1'b0);

      // R9: long idle gaps must hold the bit and the sequence
      tag = "R9";
      load(3'd1);
      for (int k = 0; k < 30; k++) begin
         repeat (3) tick(1'b0, cb(1'b1, 3'd1, 1'b0));
         tick(1'b1, cb(1'($urandom_range(1)), 3'd1, 1'b0));
      end

      // R3: long zero-limited run
      tag = "R3";
      load(3'd3); run(100000, 3'd3, 100, 1'b0);
      load(3'd3); run(4000, 3'd3, 85, 1'b1);
      $display("note: zero-limit forcing events seen = %0d", forced);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule